// File: doc/BRIEF.md
# Load-Linked Access Unit

This unit performs the first half of an atomic read-modify-write pair on a core with 64-bit registers. The core presents one request: the untranslated virtual address, the already translated physical address, and an access size of either word (32 bits) or doubleword (64 bits). The unit first checks that the virtual address is naturally aligned for that size.

If the address is misaligned, the unit raises an address-error-on-load exception and issues no memory read. It also latches the faulting address into a bad-address register, except when the core runs in debug mode.

If the address is aligned, the unit issues one read on a simple request/valid memory port and waits for the data. It then returns the value to the register file, sign-extended for words and unchanged for doublewords. In the same edge it records a link: the physical address, the virtual address and the loaded value, together with a valid flag. A later conditional store can compare against this record. A clear input drops the link valid flag.

Top module: `ll_unit`

## Requirements
- R1: A request is accepted only when `busy` is low. A word request (`req_dword`=0) is misaligned when `req_vaddr[1:0]` is nonzero. A doubleword request (`req_dword`=1) is misaligned when `req_vaddr[2:0]` is nonzero.
- R2: A misaligned request gives, one cycle after acceptance, a one-cycle `exc_valid` pulse with `exc_code` = 4 (address error on load). No `mem_req` is issued for it. `exc_code` is 0 whenever `exc_valid` is low.
- R3: On a misaligned request with `debug_mode` low, `badaddr` takes the faulting virtual address. With `debug_mode` high, `badaddr` keeps its previous value.
- R4: An exception leaves `link_valid`, `link_paddr`, `link_vaddr` and `link_value` unchanged.
- R5: An aligned request drives `mem_req` high for exactly one cycle, one cycle after acceptance. In that cycle `mem_addr` equals the request's physical address and `mem_dword` equals its size.
- R6: `busy` is high from the `mem_req` cycle until the cycle in which `mem_rvalid` is sampled high. Requests presented while `busy` is high are ignored: they cause no memory read and no exception.
- R7: One cycle after `mem_rvalid`, `rsp_valid` pulses for one cycle. For a word, `rsp_data` holds `mem_rdata[31:0]` sign-extended to 64 bits, and `mem_rdata[63:32]` is ignored. For a doubleword, `rsp_data` holds `mem_rdata` unchanged.
- R8: At completion, `link_paddr` takes the physical address, `link_vaddr` takes the virtual address, `link_value` takes the value returned on `rsp_data`, and `link_valid` is set.
- R9: `link_clear` clears `link_valid` on the next edge and leaves the stored addresses and value in place. When a clear and a completion land on the same edge, the clear wins.
- R10: After reset, `busy`, `mem_req`, `rsp_valid`, `exc_valid` and `link_valid` are low, and `badaddr` and the link registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load-linked request strobe |
| req_dword | input | 1 | Size: 0 word, 1 doubleword |
| req_vaddr | input | VA_W | Untranslated address |
| req_paddr | input | PA_W | Translated address |
| debug_mode | input | 1 | Suppresses bad-address capture |
| link_clear | input | 1 | Invalidate the link |
| busy | output | 1 | Read outstanding |
| exc_valid | output | 1 | Exception pulse |
| exc_code | output | 5 | Exception cause, 4 for load address error |
| badaddr | output | VA_W | Last captured faulting address |
| rsp_valid | output | 1 | Result pulse |
| rsp_data | output | XLEN | Extended result |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | PA_W | Memory read address |
| mem_dword | output | 1 | Memory read size |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | XLEN | Read data, word in bits 31:0 |
| link_valid | output | 1 | Link record valid |
| link_paddr | output | PA_W | Linked physical address |
| link_vaddr | output | VA_W | Linked virtual address |
| link_value | output | XLEN | Linked value |

## Verification
A wrong alignment decision shows up one cycle after acceptance. The port shows either a stray `mem_req` where an exception pulse was due, or an exception where a read was due. A sequencer stuck in its wait state keeps `busy` high and swallows every later request. A wrong pending address or size appears on `mem_addr` in the request cycle, or in the link record one cycle after the data returns. A bad extension shows in the next `rsp_data`, and a stale link flag shows on `link_valid` one edge after a clear or completion.

// File: rtl/ll_pkg.sv
package ll_pkg;

    typedef enum logic {
        SZ_WORD  = 1'b0,
        SZ_DWORD = 1'b1
    } ll_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ll_state_e;

    localparam int          EXC_W         = 5;
    localparam int          WORD_W        = 32;
    localparam logic [4:0]  EXC_ADDR_LOAD = 5'd4;

    // Low address bits that must be zero for a naturally aligned access.
    function automatic logic [2:0] align_mask(ll_size_e sz);
        return (sz == SZ_DWORD) ? 3'b111 : 3'b011;
    endfunction

endpackage

// File: rtl/ll_align_check.sv
module ll_align_check
    import ll_pkg::*;
(
    input  logic [2:0] addr_lo,
    input  ll_size_e   size,
    output logic       misaligned
);
    always_comb begin
        misaligned = |(addr_lo & align_mask(size));
    end
endmodule

// File: rtl/ll_extend.sv
module ll_extend
    import ll_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] raw,
    input  ll_size_e        size,
    output logic [XLEN-1:0] ext
);
    generate
        if (XLEN > WORD_W) begin : g_wide
            // Word results are sign-extended to register width.
            always_comb begin
                if (size == SZ_WORD)
                    ext = {{(XLEN-WORD_W){raw[WORD_W-1]}}, raw[WORD_W-1:0]};
                else
                    ext = raw;
            end
        end else begin : g_narrow
            always_comb ext = raw;
        end
    endgenerate
endmodule

// File: rtl/ll_link_store.sv
module ll_link_store #(
    parameter int VA_W = 64,
    parameter int PA_W = 48,
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set,
    input  logic            clear,
    input  logic [PA_W-1:0] set_paddr,
    input  logic [VA_W-1:0] set_vaddr,
    input  logic [XLEN-1:0] set_value,
    output logic            valid,
    output logic [PA_W-1:0] paddr,
    output logic [VA_W-1:0] vaddr,
    output logic [XLEN-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            paddr <= '0;
            vaddr <= '0;
            value <= '0;
        end else begin
            if (set) begin
                paddr <= set_paddr;
                vaddr <= set_vaddr;
                value <= set_value;
            end
            // A clear on the same edge as a new link wins.
            if (clear)
                valid <= 1'b0;
            else if (set)
                valid <= 1'b1;
        end
    end
endmodule

// File: rtl/ll_unit.sv
module ll_unit
    import ll_pkg::*;
#(
    parameter int VA_W = 64,
    parameter int PA_W = 48,
    parameter int XLEN = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_dword,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [PA_W-1:0]  req_paddr,
    input  logic             debug_mode,
    input  logic             link_clear,
    output logic             busy,
    output logic             exc_valid,
    output logic [4:0]       exc_code,
    output logic [VA_W-1:0]  badaddr,
    output logic             rsp_valid,
    output logic [XLEN-1:0]  rsp_data,
    output logic             mem_req,
    output logic [PA_W-1:0]  mem_addr,
    output logic             mem_dword,
    input  logic             mem_rvalid,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             link_valid,
    output logic [PA_W-1:0]  link_paddr,
    output logic [VA_W-1:0]  link_vaddr,
    output logic [XLEN-1:0]  link_value
);
    ll_state_e       state_q;
    logic [PA_W-1:0] pend_pa_q;
    logic [VA_W-1:0] pend_va_q;
    ll_size_e        pend_sz_q;
    logic            mem_req_q;
    logic            rsp_valid_q;
    logic [XLEN-1:0] rsp_data_q;
    logic            exc_q;
    logic [VA_W-1:0] badaddr_q;

    ll_size_e        req_sz;
    logic            req_misaligned;
    logic            accept;
    logic            complete;
    logic [XLEN-1:0] ext_data;

    assign req_sz   = req_dword ? SZ_DWORD : SZ_WORD;
    assign accept   = req_valid && (state_q == ST_IDLE);
    assign complete = (state_q == ST_WAIT) && mem_rvalid;

    ll_align_check u_align (
        .addr_lo    (req_vaddr[2:0]),
        .size       (req_sz),
        .misaligned (req_misaligned)
    );

    ll_extend #(.XLEN(XLEN)) u_ext (
        .raw  (mem_rdata),
        .size (pend_sz_q),
        .ext  (ext_data)
    );

    ll_link_store #(.VA_W(VA_W), .PA_W(PA_W), .XLEN(XLEN)) u_link (
        .clk       (clk),
        .rst       (rst),
        .set       (complete),
        .clear     (link_clear),
        .set_paddr (pend_pa_q),
        .set_vaddr (pend_va_q),
        .set_value (ext_data),
        .valid     (link_valid),
        .paddr     (link_paddr),
        .vaddr     (link_vaddr),
        .value     (link_value)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            pend_pa_q   <= '0;
            pend_va_q   <= '0;
            pend_sz_q   <= SZ_WORD;
            mem_req_q   <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
            exc_q       <= 1'b0;
            badaddr_q   <= '0;
        end else begin
            mem_req_q   <= 1'b0;
            rsp_valid_q <= 1'b0;
            exc_q       <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (req_misaligned) begin
                            exc_q <= 1'b1;
                            if (!debug_mode)
                                badaddr_q <= req_vaddr;
                        end else begin
                            state_q   <= ST_WAIT;
                            mem_req_q <= 1'b1;
                            pend_pa_q <= req_paddr;
                            pend_va_q <= req_vaddr;
                            pend_sz_q <= req_sz;
                        end
                    end
                end
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        rsp_valid_q <= 1'b1;
                        rsp_data_q  <= ext_data;
                        state_q     <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q == ST_WAIT);
    assign mem_req   = mem_req_q;
    assign mem_addr  = pend_pa_q;
    assign mem_dword = (pend_sz_q == SZ_DWORD);
    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;
    assign exc_valid = exc_q;
    assign exc_code  = exc_q ? EXC_ADDR_LOAD : 5'd0;
    assign badaddr   = badaddr_q;
endmodule

// File: rtl/ll_unit_chk.sv
module ll_unit_chk #(
    parameter int VA_W = 64,
    parameter int PA_W = 48,
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_dword,
    input logic [VA_W-1:0] req_vaddr,
    input logic            debug_mode,
    input logic            link_clear,
    input logic            busy,
    input logic            exc_valid,
    input logic [4:0]      exc_code,
    input logic [VA_W-1:0] badaddr,
    input logic            rsp_valid,
    input logic [XLEN-1:0] rsp_data,
    input logic            mem_req,
    input logic            mem_rvalid,
    input logic            link_valid,
    input logic [PA_W-1:0] link_paddr,
    input logic [VA_W-1:0] link_vaddr,
    input logic [XLEN-1:0] link_value
);
    logic bad_req;
    assign bad_req = req_valid && !busy &&
                     (req_dword ? (req_vaddr[2:0] != 3'd0) : (req_vaddr[1:0] != 2'd0));

    a_r2_fault_no_read: assert property (@(posedge clk) disable iff (rst)
        bad_req |=> (exc_valid && !mem_req && exc_code == 5'd4));

    a_r2_code_quiet: assert property (@(posedge clk) disable iff (rst)
        !exc_valid |-> (exc_code == 5'd0));

    a_r3_debug_keeps_badaddr: assert property (@(posedge clk) disable iff (rst)
        (bad_req && debug_mode) |=> $stable(badaddr));

    a_r4_exc_keeps_link: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> ($stable(link_paddr) && $stable(link_vaddr) && $stable(link_value)));

    a_r5_single_req: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    a_r6_req_while_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    a_r6_busy_ignores: assert property (@(posedge clk) disable iff (rst)
        busy |=> !exc_valid);

    a_r7_rsp_after_data: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_rvalid) |=> (rsp_valid && !busy));

    a_r8_link_matches_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (link_value == rsp_data));

    a_r9_clear_drops: assert property (@(posedge clk) disable iff (rst)
        link_clear |=> !link_valid);
endmodule

bind ll_unit ll_unit_chk #(.VA_W(VA_W), .PA_W(PA_W), .XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_dword  (req_dword),
    .req_vaddr  (req_vaddr),
    .debug_mode (debug_mode),
    .link_clear (link_clear),
    .busy       (busy),
    .exc_valid  (exc_valid),
    .exc_code   (exc_code),
    .badaddr    (badaddr),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .mem_req    (mem_req),
    .mem_rvalid (mem_rvalid),
    .link_valid (link_valid),
    .link_paddr (link_paddr),
    .link_vaddr (link_vaddr),
    .link_value (link_value)
);

// File: tb/sim_ll_unit.sv
`timescale 1ns/1ps
module sim_ll_unit;
    localparam int VA_W = 64;
    localparam int PA_W = 48;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_dword = 1'b0;
    logic [VA_W-1:0] req_vaddr = '0;
    logic [PA_W-1:0] req_paddr = '0;
    logic            debug_mode = 1'b0;
    logic            link_clear = 1'b0;
    logic            busy;
    logic            exc_valid;
    logic [4:0]      exc_code;
    logic [VA_W-1:0] badaddr;
    logic            rsp_valid;
    logic [XLEN-1:0] rsp_data;
    logic            mem_req;
    logic [PA_W-1:0] mem_addr;
    logic            mem_dword;
    logic            mem_rvalid = 1'b0;
    logic [XLEN-1:0] mem_rdata = '0;
    logic            link_valid;
    logic [PA_W-1:0] link_paddr;
    logic [VA_W-1:0] link_vaddr;
    logic [XLEN-1:0] link_value;

    always #2 clk = ~clk;

    ll_unit #(.VA_W(VA_W), .PA_W(PA_W), .XLEN(XLEN)) u0 (.*);

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Expected state model.
    logic [VA_W-1:0] e_bad  = '0;
    logic            e_lv   = 1'b0;
    logic [PA_W-1:0] e_lpa  = '0;
    logic [VA_W-1:0] e_lva  = '0;
    logic [XLEN-1:0] e_lval = '0;

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] memval(input logic [PA_W-1:0] pa);
        logic [31:0] lo;
        logic [31:0] hi;
        lo = pa[31:0] * 32'h9E37_79B1 + {16'h0, pa[47:32]};
        hi = ~lo ^ 32'h5A5A_C3C3;
        return {hi, lo};
    endfunction

    function automatic logic [63:0] expect_ext(input logic [63:0] raw, input bit dw);
        return dw ? raw : {{32{raw[31]}}, raw[31:0]};
    endfunction

    function automatic bit is_bad(input logic [VA_W-1:0] va, input bit dw);
        return dw ? (va[2:0] != 3'd0) : (va[1:0] != 2'd0);
    endfunction

    task automatic check_link(input string tag);
        chk(link_valid == e_lv,   tag, {63'd0, link_valid}, {63'd0, e_lv});
        chk(link_paddr == e_lpa,  tag, {16'd0, link_paddr}, {16'd0, e_lpa});
        chk(link_vaddr == e_lva,  tag, link_vaddr, e_lva);
        chk(link_value == e_lval, tag, link_value, e_lval);
    endtask

    // One load-linked; inputs change at negedges, outputs sampled at negedges.
    task automatic do_ll(input logic [VA_W-1:0] va, input logic [PA_W-1:0] pa,
                         input bit dw, input bit dbg, input int lat,
                         input bit poke_busy, input bit clr_at_end);
        logic [63:0] raw;
        raw = memval(pa);
        req_valid = 1'b1; req_dword = dw; req_vaddr = va;
        req_paddr = pa;   debug_mode = dbg;
        @(negedge clk);
        req_valid = 1'b0;
        if (is_bad(va, dw)) begin
            if (!dbg) e_bad = va;
            chk(exc_valid && exc_code == 5'd4, "R2 exception pulse", {59'd0, exc_code}, 64'd4);
            chk(!mem_req, "R2 no read on fault", {63'd0, mem_req}, 64'd0);
            chk(badaddr == e_bad, dbg ? "R3 debug keeps badaddr" : "R3 badaddr capture",
                badaddr, e_bad);
            check_link("R4 link unchanged on fault");
            @(negedge clk);
            chk(!exc_valid && exc_code == 5'd0, "R2 pulse ends", {63'd0, exc_valid}, 64'd0);
            return;
        end
        chk(mem_req && busy, "R5 request issued, R6 busy", {62'd0, mem_req, busy}, 64'd3);
        chk(mem_addr == pa && mem_dword == dw, "R5 request address and size",
            {15'd0, mem_dword, mem_addr}, {15'd0, dw, pa});
        for (int i = 0; i < lat; i++) begin
            if (poke_busy) begin
                req_valid = 1'b1; req_vaddr = va ^ 64'h1; req_paddr = pa ^ 48'h40;
            end
            @(negedge clk);
            req_valid = 1'b0;
            chk(busy && !mem_req && !exc_valid, "R6 busy holds and ignores requests",
                {61'd0, busy, mem_req, exc_valid}, 64'd4);
        end
        mem_rvalid = 1'b1; mem_rdata = raw;
        link_clear = clr_at_end;
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = ~raw;
        link_clear = 1'b0;
        e_lpa = pa; e_lva = va; e_lval = expect_ext(raw, dw); e_lv = !clr_at_end;
        chk(rsp_valid && !busy, "R7 response pulse", {62'd0, rsp_valid, busy}, 64'd2);
        chk(rsp_data == e_lval, dw ? "R7 doubleword passthrough" : "R7 word sign extension",
            rsp_data, e_lval);
        check_link(clr_at_end ? "R9 clear beats completion" : "R8 link record");
        @(negedge clk);
        chk(!rsp_valid && !mem_req, "R6 no read from ignored request",
            {62'd0, rsp_valid, mem_req}, 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(!busy && !mem_req && !rsp_valid && !exc_valid, "R10 reset outputs",
            {60'd0, busy, mem_req, rsp_valid, exc_valid}, 64'd0);
        chk(badaddr == '0, "R10 reset badaddr", badaddr, 64'd0);
        check_link("R10 reset link");

        // Directed corners: R1 alignment per size.
        do_ll(64'h0000_0000_1000_0004, 48'h0000_0020_0004, 1'b0, 1'b0, 0, 1'b0, 1'b0); // word aligned at 4
        do_ll(64'h0000_0000_1000_0004, 48'h0000_0020_0004, 1'b1, 1'b0, 0, 1'b0, 1'b0); // R1 dword at 4 faults
        do_ll(64'h0000_0000_1000_0002, 48'h0000_0020_0002, 1'b0, 1'b0, 2, 1'b0, 1'b0); // R1 word at 2 faults
        do_ll(64'hFFFF_FFFF_8000_0008, 48'h0000_7FFF_FFF8, 1'b1, 1'b0, 3, 1'b1, 1'b0); // dword, poke busy
        do_ll(64'h0000_0000_0000_0001, 48'h0, 1'b0, 1'b1, 0, 1'b0, 1'b0);               // R3 debug fault
        do_ll(64'h0000_0000_2000_0010, 48'h0000_0000_0010, 1'b0, 1'b0, 1, 1'b0, 1'b1);  // R9 clear+complete

        // R9 standalone clear keeps the record.
        do_ll(64'h0000_0000_3000_0020, 48'h0000_0000_1020, 1'b1, 1'b0, 0, 1'b0, 1'b0);
        link_clear = 1'b1;
        @(negedge clk);
        link_clear = 1'b0;
        e_lv = 1'b0;
        check_link("R9 clear keeps addresses");

        // Constrained random mix.
        for (int k = 0; k < 400; k++) begin
            logic [VA_W-1:0] va;
            logic [PA_W-1:0] pa;
            bit dw;
            dw = $urandom_range(0, 1);
            va = {$urandom, $urandom};
            pa = {$urandom, $urandom};
            if ($urandom_range(0, 3) != 0) va[2:0] = dw ? 3'd0 : {$urandom_range(0, 1), 2'd0};
            pa[2:0] = va[2:0];
            do_ll(va, pa, dw, ($urandom_range(0, 3) == 0), $urandom_range(0, 3),
                  ($urandom_range(0, 1) == 1), ($urandom_range(0, 7) == 0));
            if ($urandom_range(0, 9) == 0) begin
                link_clear = 1'b1;
                @(negedge clk);
                link_clear = 1'b0;
                e_lv = 1'b0;
                check_link("R9 random clear");
            end
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule